// File: doc/BRIEF.md
# DS1 Robbed-Bit Signalling Extractor

This block sits on the receive side of a DS1 (T1) line after framing. It takes a stream of timeslot octets, 24 timeslots per frame. With them come a strobe for the first octet of each frame and a strobe that marks the frame as the first of a 24-frame multiframe. From these it keeps its own count of the frame position within the multiframe. In the four frames where the line carries signalling in the low bit of every timeslot, it takes that bit out of each octet. It gathers four bits per timeslot into a signalling nibble.

Every octet is passed on one cycle later with a flag saying whether it holds only seven data bits. The signalling nibbles for all 24 timeslots are held in a small register file that a reader addresses by timeslot number. That file changes only once per multiframe, all slots together, so a reader never sees a nibble built from two different multiframes. A mode input folds the nibble for two-state signalling.

Top module: `rbs_extractor`

## Requirements
- R1: After reset every timeslot reads back signalling 4'b0000 and the data output is not valid.
- R2: An accepted octet with `frame_start` high opens a new frame. If `mf_align` is also high that frame is frame 1; otherwise the count advances by one and goes from 24 back to 1.
- R3: Each accepted octet appears on `out_octet` on the next cycle with `out_valid` high. In frames 6, 12, 18 and 24 `out_seven` is 1 and bit 0 of the octet is forced to 0. In all other frames the octet is unchanged and `out_seven` is 0.
- R4: The signalling nibble is laid out as bit 3 = A, bit 2 = B, bit 1 = C and bit 0 = D. A is bit 0 of the timeslot's octet in frame 6, B in frame 12, C in frame 18 and D in frame 24.
- R5: The register file is loaded for all timeslots at once, on the clock edge that accepts timeslot 23 of frame 24, and is readable from the following cycle. Between such edges every read returns the previous contents. Gathered bits are kept until they are overwritten, and a realignment does not clear them.
- R6: When `two_state` is 1 at the loading edge, each stored nibble is {A, B, A, B}. When it is 0, the nibble is {A, B, C, D}.
- R7: Cycles with `in_valid` low leave `out_valid` low on the next cycle and change neither the frame count nor any signalling. A read index of 24 or more returns 4'b0000.
- R8: Until the first accepted `frame_start` after reset, no octet is flagged or altered and no signalling is gathered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An octet is presented this cycle |
| in_slot | input | 5 | Timeslot number of the octet, 0 to 23 |
| in_octet | input | 8 | Timeslot octet |
| frame_start | input | 1 | Octet is the first of a frame |
| mf_align | input | 1 | With frame_start, marks frame 1 of a multiframe |
| two_state | input | 1 | 1 = store {A,B,A,B}, 0 = store {A,B,C,D} |
| out_valid | output | 1 | Registered octet valid |
| out_octet | output | 8 | Registered octet, bit 0 cleared in signalling frames |
| out_seven | output | 1 | Octet holds only seven data bits |
| rd_idx | input | 5 | Timeslot whose signalling is read |
| rd_abcd | output | 4 | Signalling nibble of that timeslot |

## Verification
The bench drives whole multiframes of random octets and predicts every output octet and every nibble. It reads all 24 slots in the middle of a multiframe, where a design that loads early would show new bits too soon. It reads them again right after the last octet of frame 24, where a design that loads before merging the final D bit would report a stale D. A realignment partway through a multiframe checks that the count restarts at 1 and not at 0 or 2, and octets sent before any frame strobe check that nothing is flagged while the block is unsynchronised. Idle cycles carrying junk data, a two-state multiframe and read indices past 23 catch designs that latch invalid octets, fail to fold C and D, or alias out-of-range reads onto real slots.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int unsigned NUM_SLOTS     = 24;
    localparam int unsigned FRAMES_PER_MF = 24;
    localparam int unsigned ROB_PERIOD    = 6;
    localparam int unsigned OCTET_W       = 8;
    localparam int unsigned SIG_BITS      = FRAMES_PER_MF / ROB_PERIOD;
    localparam int unsigned SLOT_W        = $clog2(NUM_SLOTS);
    localparam int unsigned FRAME_W       = $clog2(FRAMES_PER_MF + 1);
    localparam int unsigned SIG_IDX_W     = $clog2(SIG_BITS);

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [FRAME_W-1:0]   frame_t;
    typedef logic [OCTET_W-1:0]   octet_t;
    typedef logic [SIG_BITS-1:0]  sig_t;
    typedef logic [SIG_IDX_W-1:0] sig_idx_t;

    typedef enum logic {
        SIG_FOUR_STATE = 1'b0,
        SIG_TWO_STATE  = 1'b1
    } sig_mode_t;

    // One octet as presented at the input
    typedef struct packed {
        logic   valid;
        slot_t  slot;
        octet_t data;
    } beat_t;

    // Position information for the octet currently presented
    typedef struct packed {
        logic     robbed;   // octet belongs to a signalling frame
        sig_idx_t sig_pos;  // nibble bit that its LSB feeds
        logic     commit;   // last signalling octet of the multiframe
    } pos_t;

    function automatic frame_t advance_frame(frame_t f);
        if (f == frame_t'(FRAMES_PER_MF))
            return frame_t'(1);
        return f + frame_t'(1);
    endfunction

    function automatic logic is_sig_frame(frame_t f);
        return (f != '0) && ((int'(f) % ROB_PERIOD) == 0);
    endfunction

    // Frame 6 feeds the MSB (A), the last signalling frame feeds bit 0
    function automatic sig_idx_t sig_bit_of(frame_t f);
        return sig_idx_t'(SIG_BITS - (int'(f) / ROB_PERIOD));
    endfunction

    // Two-state folding: repeat the two upper bits into the lower two
    function automatic sig_t fold_two_state(sig_t s);
        sig_t r;
        for (int i = 0; i < int'(SIG_BITS); i++)
            r[i] = s[SIG_BITS/2 + (i % (SIG_BITS/2))];
        return r;
    endfunction

endpackage

// File: rtl/rbs_frame_tracker.sv
module rbs_frame_tracker
    import rbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  logic  frame_start,
    input  logic  mf_align,
    output pos_t  pos
);

    frame_t frame_q;
    logic   synced_q;
    frame_t cur_frame;
    logic   cur_synced;
    logic   new_frame;

    assign new_frame = beat.valid && frame_start;

    always_comb begin
        cur_frame = frame_q;
        if (new_frame)
            cur_frame = mf_align ? frame_t'(1) : advance_frame(frame_q);
    end

    assign cur_synced = synced_q || new_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= frame_t'(FRAMES_PER_MF);
            synced_q <= 1'b0;
        end else if (new_frame) begin
            frame_q  <= cur_frame;
            synced_q <= 1'b1;
        end
    end

    always_comb begin
        pos.robbed  = beat.valid && cur_synced && is_sig_frame(cur_frame);
        pos.sig_pos = sig_bit_of(cur_frame);
        pos.commit  = pos.robbed
                   && (cur_frame == frame_t'(FRAMES_PER_MF))
                   && (beat.slot == slot_t'(NUM_SLOTS - 1));
    end

endmodule

// File: rtl/rbs_octet_stage.sv
module rbs_octet_stage
    import rbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  beat_t  beat,
    input  pos_t   pos,
    output logic   out_valid,
    output octet_t out_octet,
    output logic   out_seven
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_octet <= '0;
            out_seven <= 1'b0;
        end else begin
            out_valid <= beat.valid;
            if (beat.valid) begin
                out_seven <= pos.robbed;
                out_octet <= pos.robbed ? {beat.data[OCTET_W-1:1], 1'b0}
                                        : beat.data;
            end
        end
    end

endmodule

// File: rtl/rbs_sig_store.sv
module rbs_sig_store
    import rbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  beat_t     beat,
    input  pos_t      pos,
    input  sig_mode_t mode,
    input  slot_t     rd_idx,
    output sig_t      rd_abcd
);

    sig_t gather_q [NUM_SLOTS];
    sig_t gather_nxt [NUM_SLOTS];
    sig_t table_q [NUM_SLOTS];

    // Gathered bits with the current octet's bit merged in
    always_comb begin
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            gather_nxt[i] = gather_q[i];
            if (pos.robbed && beat.slot == slot_t'(i))
                gather_nxt[i][pos.sig_pos] = beat.data[0];
        end
    end

    for (genvar g = 0; g < int'(NUM_SLOTS); g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                gather_q[g] <= '0;
                table_q[g]  <= '0;
            end else begin
                gather_q[g] <= gather_nxt[g];
                if (pos.commit)
                    table_q[g] <= (mode == SIG_TWO_STATE)
                                ? fold_two_state(gather_nxt[g])
                                : gather_nxt[g];
            end
        end
    end

    always_comb begin
        rd_abcd = '0;
        for (int i = 0; i < int'(NUM_SLOTS); i++)
            if (rd_idx == slot_t'(i))
                rd_abcd = table_q[i];
    end

endmodule

// File: rtl/rbs_extractor.sv
module rbs_extractor
    import rbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SLOT_W-1:0]   in_slot,
    input  logic [OCTET_W-1:0]  in_octet,
    input  logic                frame_start,
    input  logic                mf_align,
    input  logic                two_state,
    output logic                out_valid,
    output logic [OCTET_W-1:0]  out_octet,
    output logic                out_seven,
    input  logic [SLOT_W-1:0]   rd_idx,
    output logic [SIG_BITS-1:0] rd_abcd
);

    beat_t     beat;
    pos_t      pos;
    sig_mode_t mode;

    assign beat.valid = in_valid;
    assign beat.slot  = in_slot;
    assign beat.data  = in_octet;
    assign mode       = two_state ? SIG_TWO_STATE : SIG_FOUR_STATE;

    rbs_frame_tracker u_tracker (
        .clk         (clk),
        .rst         (rst),
        .beat        (beat),
        .frame_start (frame_start),
        .mf_align    (mf_align),
        .pos         (pos)
    );

    rbs_octet_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .pos       (pos),
        .out_valid (out_valid),
        .out_octet (out_octet),
        .out_seven (out_seven)
    );

    rbs_sig_store u_store (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat),
        .pos     (pos),
        .mode    (mode),
        .rd_idx  (rd_idx),
        .rd_abcd (rd_abcd)
    );

endmodule

// File: rtl/rbs_extractor_checker.sv
module rbs_extractor_checker
    import rbs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OCTET_W-1:0]  in_octet,
    input logic                two_state,
    input logic                out_valid,
    input logic [OCTET_W-1:0]  out_octet,
    input logic                out_seven,
    input logic [SLOT_W-1:0]   rd_idx,
    input logic [SIG_BITS-1:0] rd_abcd,
    input logic                commit
);

    // R1: data output idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

    // R3 / R7: one-cycle valid latency
    p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: unflagged octets pass unchanged, flagged octets have LSB cleared
    p_octet_pass_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_seven ? (out_octet == {$past(in_octet[OCTET_W-1:1]), 1'b0})
                                : (out_octet == $past(in_octet))));

    // R5: no change in the read value without a load
    p_table_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> (rd_idx != $past(rd_idx)) || (rd_abcd == $past(rd_abcd)));

    // R6: a load in two-state mode stores the repeated pair
    p_two_state_fold_r6: assert property (@(posedge clk) disable iff (rst)
        (commit && two_state) |=> (rd_idx != $past(rd_idx))
            || (rd_abcd[SIG_BITS/2-1:0] == rd_abcd[SIG_BITS-1:SIG_BITS/2]));

    // R7: out-of-range read index gives zero
    p_bad_index_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_idx >= SLOT_W'(NUM_SLOTS)) |-> (rd_abcd == '0));

endmodule

bind rbs_extractor rbs_extractor_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_octet  (in_octet),
    .two_state (two_state),
    .out_valid (out_valid),
    .out_octet (out_octet),
    .out_seven (out_seven),
    .rd_idx    (rd_idx),
    .rd_abcd   (rd_abcd),
    .commit    (pos.commit)
);

// File: tb/rbs_extractor_test.sv
module rbs_extractor_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, frame_start, mf_align, two_state;
    logic [4:0] in_slot, rd_idx;
    logic [7:0] in_octet, out_octet;
    logic       out_valid, out_seven;
    logic [3:0] rd_abcd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state
    int       m_frame  = 24;
    bit       m_synced = 0;
    bit [3:0] m_gather [24];
    bit [3:0] m_table  [24];

    always #10 clk = ~clk;

    rbs_extractor uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot),
        .in_octet(in_octet), .frame_start(frame_start), .mf_align(mf_align),
        .two_state(two_state), .out_valid(out_valid), .out_octet(out_octet),
        .out_seven(out_seven), .rd_idx(rd_idx), .rd_abcd(rd_abcd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit sig_frame(int f);
        return (f % 6) == 0;
    endfunction

    function automatic bit [7:0] exp_octet(bit [7:0] d, bit robbed);
        return robbed ? {d[7:1], 1'b0} : d;
    endfunction

    // Drive one octet at a falling edge, check the result one edge later
    task automatic send(input bit fs, input bit ma, input int slot, input bit [7:0] d);
        bit robbed;
        if (fs) begin
            m_synced = 1;
            m_frame  = ma ? 1 : (m_frame == 24 ? 1 : m_frame + 1);
        end
        robbed = m_synced && sig_frame(m_frame);
        if (robbed) begin
            m_gather[slot][4 - m_frame/6] = d[0];           // R4: A..D from frames 6..24
            if (m_frame == 24 && slot == 23)
                for (int i = 0; i < 24; i++)
                    m_table[i] = two_state ? {m_gather[i][3:2], m_gather[i][3:2]}
                                           : m_gather[i];
        end
        in_valid = 1; frame_start = fs; mf_align = ma;
        in_slot = 5'(slot); in_octet = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; frame_start = 0; mf_align = 0;
        check(out_valid == 1, "R3 valid", out_valid, 1);
        check(out_seven == robbed, m_synced ? "R3 flag" : "R8 flag", out_seven, robbed);
        check(out_octet == exp_octet(d, robbed), m_synced ? "R3 octet" : "R8 octet",
              out_octet, exp_octet(d, robbed));
    endtask

    task automatic idle_cycle();
        in_valid = 0; frame_start = 1; mf_align = 1;          // junk on ignored inputs
        in_slot = 5'd23; in_octet = 8'($urandom);
        @(posedge clk);
        @(negedge clk);
        frame_start = 0; mf_align = 0;
        check(out_valid == 0, "R7 idle", out_valid, 0);
    endtask

    task automatic send_frame(input bit align, input bit gaps);
        for (int s = 0; s < 24; s++) begin
            send(s == 0, align && s == 0, s, 8'($urandom));
            if (gaps && ($urandom % 4 == 0)) idle_cycle();
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            rd_idx = 5'(i);
            #1;
            check(rd_abcd == m_table[i], req, rd_abcd, m_table[i]);
        end
    endtask

    task automatic run_multiframe(input bit align, input bit gaps);
        for (int f = 0; f < 24; f++) begin
            send_frame(align && f == 0, gaps);
            if (f == 12) read_all("R5 mid-multiframe hold");
        end
        read_all("R4 R5 R6 after load");
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0019));
        for (int i = 0; i < 24; i++) begin m_gather[i] = 0; m_table[i] = 0; end
        rst = 1; in_valid = 0; frame_start = 0; mf_align = 0; two_state = 0;
        in_slot = 0; in_octet = 0; rd_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check(out_valid == 0, "R1 valid after reset", out_valid, 0);
        read_all("R1 reset table");

        // R8: octets before any frame strobe, LSB set to expose alteration
        for (int s = 0; s < 30; s++) send(0, 0, s % 24, 8'($urandom) | 8'h01);
        read_all("R8 no capture unsynced");

        // R2 R3 R4 R5: aligned multiframes, four-state, with idle gaps (R7)
        run_multiframe(1, 1);
        run_multiframe(0, 0);

        // R6: two-state multiframe
        two_state = 1;
        run_multiframe(0, 1);
        two_state = 0;

        // R2: realign partway, then a full multiframe from frame 1
        for (int f = 0; f < 9; f++) send_frame(0, 0);
        run_multiframe(1, 0);

        // Directed corner: all-ones signalling in frame 24 only
        for (int f = 1; f <= 24; f++)
            for (int s = 0; s < 24; s++)
                send(s == 0, f == 1 && s == 0, s, (f == 24) ? 8'hFF : 8'h00);
        read_all("R4 D bit only");

        // R7: out-of-range read indices
        for (int i = 24; i < 32; i++) begin
            @(negedge clk);
            rd_idx = 5'(i);
            #1;
            check(rd_abcd == 4'b0000, "R7 bad index", rd_abcd, 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule